// File: doc/BRIEF.md
# Radix-4 SRT Significand Divider

This block divides one normalized significand by another, both in the range [1,2), and returns the quotient as a plain binary number. It is meant to sit inside a floating-point divide path; exponents, signs and rounding are handled outside it. A single `start_i` pulse loads the operands. The unit then runs a fixed number of iterations and raises `done_o` for one cycle with the quotient valid.

Each iteration retires two quotient bits. The partial remainder is first multiplied by four. A quotient digit in the range minus two to plus two is then read from a selection table. The table is addressed by a short two's complement estimate of the shifted remainder, together with the leading bits of the divisor. The digit times the divisor is subtracted from the shifted remainder. Because the digit set is redundant, an early digit that overshoots is repaired by negative digits later on.

Positive and negative digits are kept in two separate shift registers. After the last step they are subtracted, and one is taken off if the final remainder is negative. For 24-bit significands the unit runs 13 iterations. The 26-bit quotient holds floor(dividend * 2^24 / divisor).

Top module: `srt_radix4_div`

## Requirements
- R1: Every selected quotient digit lies in {-2, -1, 0, +1, +2}, and each iteration appends exactly two bits of quotient weight.
- R2: The selection table has 2^11 entries. Its address is {7-bit estimate, 4-bit divisor prefix}. The 7-bit estimate is the floor of eight times the shifted remainder, in two's complement: a sign bit, three integer bits and three fraction bits. The 4-bit divisor prefix is the leading one of the divisor plus its three fraction bits below it. Every entry the remainder can reach holds a digit that keeps the recurrence bounded.
- R3: The first partial remainder is dividend/4. Each iteration forms next = 4*rem - digit*divisor.
- R4: After loading and after every iteration, the partial remainder satisfies 3*|rem| <= 2*divisor.
- R5: With ITER = (SIG_W+1)/2 + 1 iterations, the quotient equals floor(dividend * 2^(2*(ITER-1)) / divisor), with both operands read as SIG_W-bit integers whose top bit is set. A negative final remainder lowers the digit sum by one.
- R6: `done_o` is high for exactly one cycle, directly after the (ITER+2)-th rising edge, counting the edge that accepts `start_i` as the first. `quotient_o` changes only in that cycle and holds its value until the next completion.
- R7: A `start_i` that arrives while a division is in progress is ignored. It does not restart the operation, change its result or latency, or cause a second `done_o`.
- R8: While `rst_n` is low, `done_o` and `quotient_o` are zero. A reset in the middle of a division abandons it, and no `done_o` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load operands and begin a division (taken only when idle) |
| dividend_i | input | SIG_W | Dividend significand, top bit set |
| divisor_i | input | SIG_W | Divisor significand, top bit set |
| done_o | output | 1 | One-cycle pulse when the quotient is ready |
| quotient_o | output | 2*ITER | Quotient, two integer bits and 2*(ITER-1) fraction bits |

## Verification
The quotient and `done_o` become due together, ITER+2 rising edges after the edge that accepts `start_i` (15 edges at the default width). The bench counts edges from that acceptance, drives inputs and samples outputs on falling edges, and checks the exact edge count at which `done_o` is first seen. At that moment it compares the quotient against an integer division computed in the bench. One falling edge later it confirms that `done_o` has dropped and the quotient has held. For the ignored-start and mid-run-reset cases, the bench watches `done_o` over a window longer than a full division, to confirm that no extra completion appears.

// File: rtl/srt_div_pkg.sv
package srt_div_pkg;

    localparam int REM_EST_W    = 7;
    localparam int DIV_EST_W    = 4;
    localparam int SEL_W        = 3;
    localparam int SEL_ADDR_W   = REM_EST_W + DIV_EST_W;
    localparam int SEL_ENTRIES  = 1 << SEL_ADDR_W;
    localparam int REM_EST_FRAC = REM_EST_W - 4;
    localparam int DIV_EST_FRAC = DIV_EST_W - 1;

    typedef logic signed [SEL_W-1:0] digit_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_CONV = 2'd2
    } div_state_t;

    // Each cell covers remainder [e, e+1)/2^REM_EST_FRAC and divisor
    // [p, p+1)/2^DIV_EST_FRAC. A digit k fits the cell when, for every point in it,
    // (k - 2/3)d <= y <= (k + 2/3)d. Cells with no full fit lie at the outer edge
    // of the reachable range, where only the extreme digit applies.
    function automatic logic [SEL_ENTRIES*SEL_W-1:0] build_sel_table();
        logic [SEL_ENTRIES*SEL_W-1:0] tbl;
        int est;
        int pre;
        int pick;
        int lo_c;
        int up_c;
        int lo_d;
        int up_d;
        bit found;
        tbl = '0;
        for (int a = 0; a < SEL_ENTRIES; a++) begin
            est = a >> DIV_EST_W;
            if (est >= (1 << (REM_EST_W - 1)))
                est = est - (1 << REM_EST_W);
            pre   = a % (1 << DIV_EST_W);
            pick  = (est < 0) ? -2 : 2;
            found = 1'b0;
            for (int k = -2; k <= 2; k++) begin
                lo_c = 3 * k - 2;
                up_c = 3 * k + 2;
                lo_d = (lo_c > 0) ? pre + 1 : pre;
                up_d = (up_c > 0) ? pre : pre + 1;
                if (!found &&
                    (3 * est * (1 << DIV_EST_FRAC) >= lo_c * lo_d * (1 << REM_EST_FRAC)) &&
                    (3 * (est + 1) * (1 << DIV_EST_FRAC) <= up_c * up_d * (1 << REM_EST_FRAC))) begin
                    pick  = k;
                    found = 1'b1;
                end
            end
            tbl[a*SEL_W +: SEL_W] = SEL_W'(pick);
        end
        return tbl;
    endfunction

endpackage

// File: rtl/srt_digit_select.sv
module srt_digit_select
    import srt_div_pkg::*;
(
    input  logic [REM_EST_W-1:0] rem_est_i,
    input  logic [DIV_EST_W-1:0] div_est_i,
    output digit_t               digit_o
);

    localparam logic [SEL_ENTRIES*SEL_W-1:0] SEL_TABLE = build_sel_table();

    logic [SEL_W-1:0] sel_rom [SEL_ENTRIES];

    for (genvar g = 0; g < SEL_ENTRIES; g++) begin : g_rom
        assign sel_rom[g] = SEL_TABLE[g*SEL_W +: SEL_W];
    end

    assign digit_o = digit_t'(sel_rom[{rem_est_i, div_est_i}]);

endmodule

// File: rtl/srt_rem_step.sv
module srt_rem_step
    import srt_div_pkg::*;
#(
    parameter int RW = 29
) (
    input  logic signed [RW-1:0]        rem_i,
    input  logic        [RW-1:0]        div_i,
    input  digit_t                      digit_i,
    output logic signed [RW-1:0]        rem_next_o,
    output logic        [REM_EST_W-1:0] rem_est_o
);

    logic signed [RW-1:0] shifted;
    logic signed [RW-1:0] multiple;

    assign shifted   = rem_i <<< 2;
    assign rem_est_o = shifted[RW-1 -: REM_EST_W];

    always_comb begin
        case (digit_i)
            3'sd1:   multiple = $signed(div_i);
            3'sd2:   multiple = $signed(div_i << 1);
            -3'sd1:  multiple = -$signed(div_i);
            -3'sd2:  multiple = -$signed(div_i << 1);
            default: multiple = '0;
        endcase
        rem_next_o = shifted - multiple;
    end

endmodule

// File: rtl/srt_quot_convert.sv
module srt_quot_convert #(
    parameter int QW = 26
) (
    input  logic [QW-1:0] pos_i,
    input  logic [QW-1:0] neg_i,
    input  logic          rem_neg_i,
    output logic [QW-1:0] quot_o
);

    assign quot_o = pos_i - neg_i - QW'(rem_neg_i);

endmodule

// File: rtl/srt_radix4_div.sv
module srt_radix4_div
    import srt_div_pkg::*;
#(
    parameter int SIG_W = 24
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start_i,
    input  logic [SIG_W-1:0]                dividend_i,
    input  logic [SIG_W-1:0]                divisor_i,
    output logic                            done_o,
    output logic [2*((SIG_W+1)/2+1)-1:0]    quotient_o
);

    localparam int ITER  = (SIG_W + 1) / 2 + 1;
    localparam int QW    = 2 * ITER;
    localparam int FR    = SIG_W + 1;
    localparam int RW    = FR + 4;
    localparam int CNT_W = $clog2(ITER);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ITER - 1);

    typedef struct packed {
        div_state_t           st;
        logic [CNT_W-1:0]     cnt;
        logic signed [RW-1:0] w;
        logic [SIG_W-1:0]     dvs;
        logic [QW-1:0]        qpos;
        logic [QW-1:0]        qneg;
        logic [QW-1:0]        quot;
        logic                 done;
    } div_regs_t;

    div_regs_t r_q;
    div_regs_t r_d;

    logic [RW-1:0]        div_al;
    logic [REM_EST_W-1:0] rem_est;
    digit_t               digit;
    logic signed [RW-1:0] w_next;
    logic [QW-1:0]        quot_conv;
    logic [1:0]           pos_mag;
    logic [1:0]           neg_mag;

    assign div_al = RW'({r_q.dvs, 2'b00});

    srt_rem_step #(.RW(RW)) u_step (
        .rem_i      (r_q.w),
        .div_i      (div_al),
        .digit_i    (digit),
        .rem_next_o (w_next),
        .rem_est_o  (rem_est)
    );

    srt_digit_select u_select (
        .rem_est_i (rem_est),
        .div_est_i (r_q.dvs[SIG_W-1 -: DIV_EST_W]),
        .digit_o   (digit)
    );

    srt_quot_convert #(.QW(QW)) u_convert (
        .pos_i     (r_q.qpos),
        .neg_i     (r_q.qneg),
        .rem_neg_i (r_q.w[RW-1]),
        .quot_o    (quot_conv)
    );

    always_comb begin
        pos_mag = digit[SEL_W-1] ? 2'b00 : digit[1:0];
        neg_mag = digit[SEL_W-1] ? 2'(-digit) : 2'b00;
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_RUN;
                    r_d.cnt  = '0;
                    r_d.w    = RW'(dividend_i);
                    r_d.dvs  = divisor_i;
                    r_d.qpos = '0;
                    r_d.qneg = '0;
                end
            end
            ST_RUN: begin
                r_d.w    = w_next;
                r_d.qpos = {r_q.qpos[QW-3:0], pos_mag};
                r_d.qneg = {r_q.qneg[QW-3:0], neg_mag};
                r_d.cnt  = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST)
                    r_d.st = ST_CONV;
            end
            ST_CONV: begin
                r_d.quot = quot_conv;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o     = r_q.done;
    assign quotient_o = r_q.quot;

    // Remainder bound terms
    logic [RW-1:0] abs_w;
    logic [RW+2:0] rem3;
    logic [RW+2:0] div2;

    always_comb begin
        abs_w = r_q.w[RW-1] ? RW'(-r_q.w) : RW'(r_q.w);
        rem3  = {3'b000, abs_w} * (RW+3)'(3);
        div2  = {2'b00, div_al, 1'b0};
    end

    assert_digit_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN) |-> ($signed(digit) >= -3'sd2 && $signed(digit) <= 3'sd2));

    assert_rem_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |-> (rem3 <= div2));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_quot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(quotient_o) |-> done_o);

    assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && r_q.st == ST_RUN) |=> !(r_q.st == ST_RUN && r_q.cnt == '0));

endmodule

// File: tb/srt_radix4_div_bench.sv
module srt_radix4_div_bench;

    localparam int SIG_W      = 24;
    localparam int ITER       = (SIG_W + 1) / 2 + 1;
    localparam int QW         = 2 * ITER;
    localparam int LAT        = ITER + 2;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 12;

    // {dividend, divisor}
    localparam logic [2*SIG_W-1:0] VECS [NVEC] = '{
        {24'h800000, 24'h800000},
        {24'hFFFFFF, 24'h800000},
        {24'h800000, 24'hFFFFFF},
        {24'h800A76, 24'hBFFFFC},
        {24'hC00000, 24'hA00000},
        {24'hAAAAAA, 24'hD55555},
        {24'hFFFFFF, 24'hFFFFFF},
        {24'h900000, 24'hF00000},
        {24'hB504F3, 24'h800001},
        {24'hE38E39, 24'hC00000},
        {24'h81A5C3, 24'hFFFFFE},
        {24'hF0F0F0, 24'h8F0F0F}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [SIG_W-1:0] dvd = '0;
    logic [SIG_W-1:0] dvs = '0;
    logic             done;
    logic [QW-1:0]    quot;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    srt_radix4_div #(.SIG_W(SIG_W)) u_srt_radix4_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .dividend_i (dvd),
        .divisor_i  (dvs),
        .done_o     (done),
        .quotient_o (quot)
    );

    function automatic logic [QW-1:0] expect_q(input logic [SIG_W-1:0] x, input logic [SIG_W-1:0] d);
        longint unsigned num;
        num = longint'(x) << (2 * (ITER - 1));
        return QW'(num / longint'(d));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_done(inout int lat);
        while (!done && lat < 4 * LAT) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic count_dones(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (done) n++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL R6 watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        int n;
        logic [QW-1:0] held;

        // R8: reset state
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R8", "done in reset", longint'(done), 0);
        check(quot == '0, "R8", "quotient in reset", longint'(quot), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4 R5 R6: vector table
        for (int v = 0; v < NVEC; v++) begin
            dvd   = VECS[v][2*SIG_W-1 -: SIG_W];
            dvs   = VECS[v][SIG_W-1:0];
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            lat   = 1;
            wait_done(lat);
            check(lat == LAT, "R6", $sformatf("vec %0d latency", v), lat, LAT);
            check(quot == expect_q(VECS[v][2*SIG_W-1 -: SIG_W], VECS[v][SIG_W-1:0]),
                  "R1/R2/R3/R4/R5", $sformatf("vec %0d quotient", v), longint'(quot),
                  longint'(expect_q(VECS[v][2*SIG_W-1 -: SIG_W], VECS[v][SIG_W-1:0])));
            held = quot;
            @(negedge clk);
            check(done == 1'b0, "R6", $sformatf("vec %0d done pulse width", v), longint'(done), 0);
            check(quot == held, "R6", $sformatf("vec %0d quotient hold", v), longint'(quot), longint'(held));
        end

        // R7: start while busy is ignored
        dvd   = 24'hC00000;
        dvs   = 24'h900000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat   = 1;
        repeat (3) begin
            @(negedge clk);
            lat++;
        end
        dvd   = 24'hFFFFFF;
        dvs   = 24'h800000;
        start = 1'b1;
        @(negedge clk);
        lat++;
        start = 1'b0;
        wait_done(lat);
        check(lat == LAT, "R7", "busy start latency", lat, LAT);
        check(quot == expect_q(24'hC00000, 24'h900000), "R7", "busy start quotient",
              longint'(quot), longint'(expect_q(24'hC00000, 24'h900000)));
        count_dones(LAT + 4, n);
        check(n == 0, "R7", "extra done after busy start", n, 0);

        // R8: reset in the middle of a run
        dvd   = 24'hA00000;
        dvs   = 24'hC00000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R8", "done after mid-run reset", longint'(done), 0);
        check(quot == '0, "R8", "quotient after mid-run reset", longint'(quot), 0);
        rst_n = 1'b1;
        count_dones(LAT + 4, n);
        check(n == 0, "R8", "done after abandoned run", n, 0);

        // R5: run after reset recovery, self-ratio
        dvd   = 24'hFFFFFF;
        dvs   = 24'hFFFFFF;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat   = 1;
        wait_done(lat);
        check(quot == QW'(1 << (2 * (ITER - 1))), "R5", "unit ratio after reset",
              longint'(quot), longint'(1 << (2 * (ITER - 1))));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule